// File: doc/BRIEF.md
# Character-synchronous receive block framer

This block sits after byte alignment on a character-synchronous receive line. It takes one aligned byte per `in_valid` strobe and decides which bytes belong to the current block and where each block ends. SYNC fill is dropped. Every delivered byte comes out on a one-cycle data strobe. A running block check sequence (BCS) is kept over the delivered bytes, and software-style commands can restart the check or leave single bytes out of it.

Block ends are found by an eight-entry control-character table. Each entry carries a character, a valid flag, a "check follows" flag and a "re-hunt" flag. An entry with "check follows" set makes the next two bytes the received check. Those bytes are compared with the computed value before the block closes. An entry without the flag closes the block at once as an abort with no check. In transparent mode a control character counts only when a DLE comes right before it. The leading DLE is stripped and kept out of the check. After a block whose entry asks for re-hunt, the framer discards bytes until the aligner delivers a SYNC again.

Top module: `bsc_rx_framer`

## Requirements
- R1: With transparent mode off, a byte equal to `cfg_sync` in the data phase is not delivered and does not enter the BCS. With transparent mode on, the same holds for a SYNC that does not follow a DLE.
- R2: With transparent mode off, a delivered byte matching the character of a valid table entry ends the block. When several valid entries match, the lowest index wins, and that index is reported in `eob_status[2:0]`. An entry with its valid bit clear never matches. Entry i uses `tbl_char[8i+7:8i]`, `tbl_valid[i]`, `tbl_chk[i]` and `tbl_hunt[i]`.
- R3: After a match on an entry with `tbl_chk` set, the next two accepted bytes are the received check, low byte first. They are not delivered. `bcs_rx` becomes {second, first}. `eob_valid` pulses in the cycle after the second check byte, and `eob_status[4]` is set exactly when `bcs_rx` differs from `bcs_calc`.
- R4: A match on an entry with `tbl_chk` clear closes the block in the same cycle the control byte is delivered. In that case `eob_status[3]` is set, `eob_status[4]` is clear and `bcs_rx` is zero.
- R5: In transparent mode a DLE not preceded by a pending DLE is stripped and sets a pending flag. The byte after it is delivered, and only that byte is checked against the table. Bytes that match the table without a leading DLE are plain data.
- R6: In transparent mode a DLE followed by a DLE delivers one DLE as data, and that DLE is included in the BCS.
- R7: The BCS is CRC-16 with polynomial x^16+x^15+x^2+1, initial value zero, processed least significant bit first. It covers every delivered byte, the closing control character included, except excluded bytes. `bcs_calc` shows its value at block close. The accumulator restarts at zero for the next block.
- R8: `cmd_bcs_reset` with a delivered byte clears the accumulator and leaves that byte out of the BCS. The byte is still delivered.
- R9: `cmd_bcs_excl` with a delivered byte leaves that byte out of the BCS. The byte is still delivered.
- R10: When the closing entry has `tbl_hunt` set, `eob_status[5]` is set. Following bytes are then discarded without output and without BCS effect until a SYNC is seen, and the byte after that SYNC starts a new block.
- R11: `byte_evt` pulses with `data_valid` only while `cfg_byte_evt_en` is set.
- R12: After reset all outputs are zero. A delivered byte appears on `data_byte` with `data_valid` one clock after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Aligned received byte is present |
| in_byte | input | 8 | Received byte |
| cfg_transparent | input | 1 | Transparent mode enable |
| cfg_byte_evt_en | input | 1 | Per-byte event enable |
| cfg_sync | input | 8 | SYNC character code |
| cfg_dle | input | 8 | DLE character code |
| cmd_bcs_reset | input | 1 | Restart the BCS and exclude this byte |
| cmd_bcs_excl | input | 1 | Exclude this byte from the BCS |
| tbl_char | input | 8*NCTL | Control-table characters, entry i at bits 8i+7:8i |
| tbl_valid | input | NCTL | Control-table entry valid flags |
| tbl_chk | input | NCTL | Control-table "check follows" flags |
| tbl_hunt | input | NCTL | Control-table "re-hunt" flags |
| data_valid | output | 1 | Delivered data byte strobe |
| data_byte | output | 8 | Delivered data byte |
| byte_evt | output | 1 | Per-byte event |
| eob_valid | output | 1 | End-of-block strobe |
| eob_status | output | clog2(NCTL)+3 | {hunt, check error, no check, entry index} |
| bcs_calc | output | 16 | Computed BCS at block close |
| bcs_rx | output | 16 | Received BCS at block close |

## Verification
On every cycle the assertions guard several properties. No SYNC leaves the framer in plain mode. Check bytes and hunted bytes produce no output. An abort never reports a check error. The per-byte event never fires without data. The accumulator is back at zero whenever a block end is reported, and a reset command leaves it at zero. Only the bench's scenarios can show the rest, because it needs whole byte sequences compared with an independently computed CRC. That covers the check value itself, the lowest-index choice among duplicate entries, DLE stripping and DLE-DLE folding, exclusion of single bytes, and the discarding of bytes until a SYNC ends the re-hunt.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  localparam int CHAR_W = 8;
  localparam int BCS_W  = 16;
  // x^16 + x^15 + x^2 + 1 in bit-reflected form
  localparam logic [BCS_W-1:0] BCS_POLY_REFL = 16'hA001;

  typedef enum logic [1:0] {
    ST_RX   = 2'd0,
    ST_CK1  = 2'd1,
    ST_CK2  = 2'd2,
    ST_HUNT = 2'd3
  } rx_state_e;

  // One byte into the reflected CRC, least significant bit first
  function automatic logic [BCS_W-1:0] bcs_step(input logic [BCS_W-1:0] crc,
                                                input logic [CHAR_W-1:0] b);
    logic [BCS_W-1:0] c;
    c = crc;
    for (int i = 0; i < CHAR_W; i++) begin
      if (c[0] ^ b[i]) c = (c >> 1) ^ BCS_POLY_REFL;
      else             c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/bsc_bcs_acc.sv
module bsc_bcs_acc
  import bsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              add,
  input  logic              clear_blk,
  input  logic [CHAR_W-1:0] byte_i,
  output logic [BCS_W-1:0]  acc_q,
  output logic [BCS_W-1:0]  acc_upd
);

  logic [BCS_W-1:0] base;

  always_comb begin
    base    = restart ? '0 : acc_q;
    acc_upd = add ? bcs_step(base, byte_i) : base;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              acc_q <= '0;
    else if (clear_blk)      acc_q <= '0;
    else if (restart || add) acc_q <= acc_upd;
  end

  AST_RESTART_LEAVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !add) |=> (acc_q == '0)); // R8

endmodule

// File: rtl/bsc_ctl_match.sv
module bsc_ctl_match
  import bsc_pkg::*;
#(
  parameter int NCTL = 8,
  localparam int IDXW = (NCTL > 1) ? $clog2(NCTL) : 1
)(
  input  logic [CHAR_W-1:0]      byte_i,
  input  logic [NCTL*CHAR_W-1:0] tbl_char,
  input  logic [NCTL-1:0]        tbl_valid,
  input  logic [NCTL-1:0]        tbl_chk,
  input  logic [NCTL-1:0]        tbl_hunt,
  output logic                   hit,
  output logic [IDXW-1:0]        idx,
  output logic                   chk,
  output logic                   hunt
);

  logic [NCTL-1:0] eq;

  for (genvar g = 0; g < NCTL; g++) begin : g_entry
    assign eq[g] = tbl_valid[g] && (tbl_char[g*CHAR_W +: CHAR_W] == byte_i);
  end

  // Scan from the top so the lowest matching index is the last written
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NCTL - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit = 1'b1;
        idx = IDXW'(i);
      end
    end
    chk  = hit && tbl_chk[idx];
    hunt = hit && tbl_hunt[idx];
  end

endmodule

// File: rtl/bsc_rx_framer.sv
module bsc_rx_framer
  import bsc_pkg::*;
#(
  parameter int NCTL = 8
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [7:0]                 in_byte,
  input  logic                       cfg_transparent,
  input  logic                       cfg_byte_evt_en,
  input  logic [7:0]                 cfg_sync,
  input  logic [7:0]                 cfg_dle,
  input  logic                       cmd_bcs_reset,
  input  logic                       cmd_bcs_excl,
  input  logic [NCTL*8-1:0]          tbl_char,
  input  logic [NCTL-1:0]            tbl_valid,
  input  logic [NCTL-1:0]            tbl_chk,
  input  logic [NCTL-1:0]            tbl_hunt,
  output logic                       data_valid,
  output logic [7:0]                 data_byte,
  output logic                       byte_evt,
  output logic                       eob_valid,
  output logic [$clog2(NCTL)+2:0]    eob_status,
  output logic [15:0]                bcs_calc,
  output logic [15:0]                bcs_rx
);

  localparam int IDXW  = (NCTL > 1) ? $clog2(NCTL) : 1;
  localparam int STW   = IDXW + 3;
  localparam int B_NCK = IDXW;
  localparam int B_ERR = IDXW + 1;

  rx_state_e        st;
  logic             dle_pend;
  logic [7:0]       rx_lo;
  logic [IDXW-1:0]  cur_idx;
  logic             cur_hunt;

  // decode
  logic             is_sync, is_dle, in_rx;
  logic             m_hit, m_chk, m_hunt;
  logic [IDXW-1:0]  m_idx;
  logic             deliver, take_ctl, dle_set, close_ck, close_ab, close_now;
  logic             bcs_restart, bcs_add;
  logic [15:0]      acc_q, acc_upd;
  logic [15:0]      rx_full;

  assign is_sync = (in_byte == cfg_sync);
  assign is_dle  = (in_byte == cfg_dle);
  assign in_rx   = in_valid && (st == ST_RX);
  assign rx_full = {in_byte, rx_lo};

  bsc_ctl_match #(.NCTL(NCTL)) u_match (
    .byte_i    (in_byte),
    .tbl_char  (tbl_char),
    .tbl_valid (tbl_valid),
    .tbl_chk   (tbl_chk),
    .tbl_hunt  (tbl_hunt),
    .hit       (m_hit),
    .idx       (m_idx),
    .chk       (m_chk),
    .hunt      (m_hunt)
  );

  always_comb begin
    deliver  = 1'b0;
    take_ctl = 1'b0;
    if (in_rx) begin
      if (!cfg_transparent) begin
        if (!is_sync) begin
          deliver  = 1'b1;
          take_ctl = m_hit;
        end
      end else if (dle_pend) begin
        deliver  = 1'b1;
        take_ctl = m_hit && !is_dle;
      end else if (!is_dle && !is_sync) begin
        deliver  = 1'b1;
      end
    end
    dle_set     = in_rx && cfg_transparent && !dle_pend && is_dle;
    close_ab    = take_ctl && !m_chk;
    close_ck    = in_valid && (st == ST_CK2);
    close_now   = close_ab || close_ck;
    bcs_restart = deliver && cmd_bcs_reset;
    bcs_add     = deliver && !cmd_bcs_reset && !cmd_bcs_excl;
  end

  bsc_bcs_acc u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (bcs_restart),
    .add       (bcs_add),
    .clear_blk (close_now),
    .byte_i    (in_byte),
    .acc_q     (acc_q),
    .acc_upd   (acc_upd)
  );

  // state and pending-DLE tracking
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_RX;
      dle_pend <= 1'b0;
      rx_lo    <= '0;
      cur_idx  <= '0;
      cur_hunt <= 1'b0;
    end else begin
      if (close_now)           dle_pend <= 1'b0;
      else if (dle_set)        dle_pend <= 1'b1;
      else if (in_rx)          dle_pend <= 1'b0;

      if (take_ctl) begin
        cur_idx  <= m_idx;
        cur_hunt <= m_hunt;
      end

      unique case (st)
        ST_RX: begin
          if (take_ctl && m_chk)      st <= ST_CK1;
          else if (close_ab && m_hunt) st <= ST_HUNT;
        end
        ST_CK1: if (in_valid) begin
          rx_lo <= in_byte;
          st    <= ST_CK2;
        end
        ST_CK2: if (in_valid) st <= cur_hunt ? ST_HUNT : ST_RX;
        ST_HUNT: if (in_valid && is_sync) st <= ST_RX;
        default: st <= ST_RX;
      endcase
    end
  end

  // output registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_valid <= 1'b0;
      data_byte  <= '0;
      byte_evt   <= 1'b0;
      eob_valid  <= 1'b0;
      eob_status <= '0;
      bcs_calc   <= '0;
      bcs_rx     <= '0;
    end else begin
      data_valid <= deliver;
      byte_evt   <= deliver && cfg_byte_evt_en;
      eob_valid  <= close_now;
      if (deliver) data_byte <= in_byte;
      if (close_ab) begin
        eob_status <= {m_hunt, 1'b0, 1'b1, m_idx};
        bcs_calc   <= acc_upd;
        bcs_rx     <= '0;
      end else if (close_ck) begin
        eob_status <= {cur_hunt, (rx_full != acc_q), 1'b0, cur_idx};
        bcs_calc   <= acc_upd;
        bcs_rx     <= rx_full;
      end
    end
  end

  AST_SYNC_NEVER_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && !$past(cfg_transparent)) |-> (data_byte != $past(cfg_sync))); // R1
  AST_CHECK_BYTES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CK1 || st == ST_CK2) |=> !data_valid); // R3
  AST_ABORT_NO_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    (eob_valid && eob_status[B_NCK]) |-> !eob_status[B_ERR]); // R4
  AST_BCS_ZERO_AT_EOB: assert property (@(posedge clk) disable iff (!rst_n)
    eob_valid |-> (acc_q == 16'h0)); // R7
  AST_HUNT_DISCARDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HUNT) |=> (!data_valid && !eob_valid)); // R10
  AST_EVT_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    byte_evt |-> data_valid); // R11

  initial begin
    if (STW != $bits(eob_status)) $display("status width mismatch");
  end

endmodule

// File: tb/bsc_rx_framer_test.sv
module bsc_rx_framer_test;

  localparam int NCTL = 8;
  localparam logic [7:0] C_SYNC = 8'h16, C_DLE = 8'h10, C_STX = 8'h02, C_SOH = 8'h01;
  localparam logic [7:0] C_ETX = 8'h03, C_ENQ = 8'h05, C_ETB = 8'h17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic cfg_transparent = 1'b0, cfg_byte_evt_en = 1'b1;
  logic cmd_bcs_reset = 1'b0, cmd_bcs_excl = 1'b0;
  logic [NCTL*8-1:0] tbl_char;
  logic [NCTL-1:0] tbl_valid, tbl_chk, tbl_hunt;
  logic data_valid, byte_evt, eob_valid;
  logic [7:0] data_byte;
  logic [5:0] eob_status;
  logic [15:0] bcs_calc, bcs_rx;

  int checks = 0, errors = 0;
  logic [15:0] mdl = '0;   // non-reflected running model

  logic [7:0]  q_db[$];
  string       q_dt[$];
  logic [5:0]  q_es[$];
  logic [15:0] q_ec[$], q_er[$];
  string       q_et[$];

  always #2 clk = ~clk;

  bsc_rx_framer #(.NCTL(NCTL)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .cfg_transparent(cfg_transparent), .cfg_byte_evt_en(cfg_byte_evt_en),
    .cfg_sync(C_SYNC), .cfg_dle(C_DLE), .cmd_bcs_reset(cmd_bcs_reset),
    .cmd_bcs_excl(cmd_bcs_excl), .tbl_char(tbl_char), .tbl_valid(tbl_valid),
    .tbl_chk(tbl_chk), .tbl_hunt(tbl_hunt), .data_valid(data_valid),
    .data_byte(data_byte), .byte_evt(byte_evt), .eob_valid(eob_valid),
    .eob_status(eob_status), .bcs_calc(bcs_calc), .bcs_rx(bcs_rx));

  // MSB-first CRC over bits fed in LSB order; reversed at the end
  function automatic logic [15:0] model_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb = r[15] ^ b[i];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h8005;
    end
    return r;
  endfunction

  function automatic logic [15:0] rev16(input logic [15:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[15-i];
    return r;
  endfunction

  function automatic logic [5:0] stat(input logic h, input logic e, input logic n, input int ix);
    return {h, e, n, 3'(ix)};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // driver side
  task automatic exp_byte(input logic [7:0] b, input bit rst, input bit inbcs, input string tag);
    if (rst) mdl = '0;
    if (inbcs) mdl = model_step(mdl, b);
    q_db.push_back(b);
    q_dt.push_back(tag);
  endtask

  task automatic exp_eob(input logic [5:0] s, input logic [15:0] rxv, input string tag);
    q_es.push_back(s);
    q_ec.push_back(rev16(mdl));
    q_er.push_back(rxv);
    q_et.push_back(tag);
    mdl = '0;
  endtask

  task automatic send(input logic [7:0] b, input bit rst = 1'b0, input bit excl = 1'b0);
    in_valid = 1'b1; in_byte = b; cmd_bcs_reset = rst; cmd_bcs_excl = excl;
    @(posedge clk); #1;
    in_valid = 1'b0; cmd_bcs_reset = 1'b0; cmd_bcs_excl = 1'b0;
  endtask

  task automatic data(input logic [7:0] b, input string tag);
    exp_byte(b, 1'b0, 1'b1, tag);
    send(b);
  endtask

  task automatic close_abort(input logic [7:0] b, input int ix, input bit h, input string tag);
    exp_byte(b, 1'b0, 1'b1, tag);
    exp_eob(stat(h, 1'b0, 1'b1, ix), 16'h0, tag);
    send(b);
  endtask

  task automatic check_seq(input bit good, input int ix, input string tag);
    logic [15:0] v, r;
    v = rev16(mdl);
    r = good ? v : (v ^ 16'h0100);
    exp_eob(stat(1'b0, !good, 1'b0, ix), r, tag);
    send(r[7:0]);
    send(r[15:8]);
  endtask

  // monitor side
  always @(negedge clk) begin
    if (rst_n) begin
      if (data_valid) begin
        if (q_db.size() == 0) check(1'b0, "R1/R10", "unexpected data", {8'h0, data_byte}, 16'h0);
        else begin
          logic [7:0] eb; string t;
          eb = q_db.pop_front(); t = q_dt.pop_front();
          check(data_byte == eb, t, "data_byte", {8'h0, data_byte}, {8'h0, eb});
          check(byte_evt == cfg_byte_evt_en, "R11", "byte_evt", {15'h0, byte_evt}, {15'h0, cfg_byte_evt_en});
        end
      end else if (byte_evt) check(1'b0, "R11", "byte_evt without data", 16'h1, 16'h0);
      if (eob_valid) begin
        if (q_es.size() == 0) check(1'b0, "R2/R10", "unexpected eob", {10'h0, eob_status}, 16'h0);
        else begin
          logic [5:0] es; logic [15:0] ec, er; string t;
          es = q_es.pop_front(); ec = q_ec.pop_front(); er = q_er.pop_front(); t = q_et.pop_front();
          check(eob_status == es, t, "eob_status", {10'h0, eob_status}, {10'h0, es});
          check(bcs_calc == ec, {t, " R7"}, "bcs_calc", bcs_calc, ec);
          check(bcs_rx == er, t, "bcs_rx", bcs_rx, er);
        end
      end
    end
  end

  bit done = 1'b0;
  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tbl_char = '0; tbl_valid = '0; tbl_chk = '0; tbl_hunt = '0;
    tbl_char[0*8 +: 8] = C_ETX; tbl_valid[0] = 1'b1; tbl_chk[0] = 1'b1;
    tbl_char[1*8 +: 8] = C_ENQ; tbl_valid[1] = 1'b1;
    tbl_char[2*8 +: 8] = 8'h5A; tbl_valid[2] = 1'b1;
    tbl_char[3*8 +: 8] = C_ETB; tbl_valid[3] = 1'b1; tbl_hunt[3] = 1'b1;
    tbl_char[4*8 +: 8] = 8'h41;                       // invalid entry
    tbl_char[5*8 +: 8] = 8'h5A; tbl_valid[5] = 1'b1; tbl_chk[5] = 1'b1;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    check(!data_valid && !eob_valid && !byte_evt, "R12", "strobes after reset",
          {13'h0, data_valid, eob_valid, byte_evt}, 16'h0);
    check(eob_status == '0 && bcs_calc == '0 && bcs_rx == '0, "R12", "status after reset",
          bcs_calc | bcs_rx | {10'h0, eob_status}, 16'h0);
    @(posedge clk); #1;

    // Block A: SYNC strip, reset command, invalid entry, exclude, good check
    send(C_SYNC); send(C_SYNC);                        // R1
    data(8'h50, "R12");
    exp_byte(C_SOH, 1'b1, 1'b0, "R8"); send(C_SOH, 1'b1, 1'b0);
    data(8'h41, "R2 invalid entry");
    send(C_SYNC);                                      // R1 mid-block
    data(8'h42, "R1");
    exp_byte(8'h43, 1'b0, 1'b0, "R9"); send(8'h43, 1'b0, 1'b1);
    data(C_ETX, "R3");
    check_seq(1'b1, 0, "R3 good check");

    // Block B: per-byte events off, bad check
    cfg_byte_evt_en = 1'b0;
    data(8'h44, "R11"); data(8'h45, "R11"); data(C_ETX, "R3");
    check_seq(1'b0, 0, "R3 bad check");
    cfg_byte_evt_en = 1'b1;

    // Block C: abort without check
    data(8'h46, "R4");
    close_abort(C_ENQ, 1, 1'b0, "R4 abort");

    // Block D: duplicate entries, lowest index wins
    data(8'h47, "R2");
    close_abort(8'h5A, 2, 1'b0, "R2 priority");

    // Block E: transparent
    cfg_transparent = 1'b1;
    send(C_DLE);                                       // stripped R5
    data(C_STX, "R5");
    data(8'h78, "R5");
    data(C_ETX, "R5 raw ETX is data");
    send(C_SYNC);                                      // R1 transparent
    send(C_DLE);
    data(C_DLE, "R6 DLE DLE");
    data(C_ENQ, "R5 raw ENQ is data");
    send(C_DLE);
    data(C_ETX, "R5 DLE ETX");
    check_seq(1'b1, 0, "R5 transparent check");
    cfg_transparent = 1'b0;

    // Block F: re-hunt
    data(8'h48, "R10");
    close_abort(C_ETB, 3, 1'b1, "R10 hunt flag");
    send(8'h41); send(8'h51); send(C_ENQ);             // discarded R10
    send(C_SYNC);
    data(8'h42, "R10 after SYNC");
    close_abort(C_ENQ, 1, 1'b0, "R10 new block");

    repeat (6) @(posedge clk);
    check(q_db.size() == 0, "R12", "pending data items", 16'(q_db.size()), 16'h0);
    check(q_es.size() == 0, "R3", "pending eob items", 16'(q_es.size()), 16'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule